// File: doc/BRIEF.md
# Byte-Wide Static Memory with Clock Register Window

This block is a synchronous model of an 8K x 8 byte-wide static memory. The eight highest addresses do not reach the memory array. They are steered to a port that faces a separate clock/calendar register bank. A pair of chip enables, one active low and one active high, is decoded together with an output enable and a write enable into one of four access modes: deselected, read, write, or selected with outputs disabled.

The data bus is modelled as a read-data vector plus a drive flag, which stands in for a tri-state pad. Read data comes from the array or from the clock port and is registered, so it appears one clock after the request. A write that falls in the clock window produces a one-cycle strobe toward the clock bank, carrying the register index and the byte. The array is left untouched.

A power-fail input overrides every enable combination and holds a power-fail output low while it is asserted. The array has no reset, so its content at power-up is undefined.

Top module: `bytewide_rtc_ram`

## Requirements
- R1: While reset is held and on the first clock after it, `bus_drive` is 0, `rdata` is 0 and `rtc_wr_stb` is 0.
- R2: A read (`sel_n`=0, `sel`=1, `oe_n`=0, `we_n`=1, `pfail`=0) of a RAM address below 0x1FF8 raises `bus_drive` and presents the stored byte on `rdata` one clock later. This holds at both ends of the RAM range (0x0000 and 0x1FF7).
- R3: When `sel_n`=1 or `sel`=0, the block is deselected: a write request changes no RAM byte, raises no strobe, and `bus_drive` stays 0.
- R4: With both enables active and `we_n`=0, a write takes place whatever the value of `oe_n`, and `bus_drive` stays 0 during a write.
- R5: With both enables active and `oe_n`=1, `we_n`=1, `bus_drive` stays 0 (outputs disabled).
- R6: A read of address 0x1FF8+k (k = 0 control, 1 seconds, 2 minutes, 3 hour, 4 day, 5 date, 6 month, 7 year) places k on `rtc_rd_idx` in the same cycle and returns `rtc_rdata` one clock later.
- R7: A write to 0x1FF8+k raises `rtc_wr_stb` for exactly the following clock, with `rtc_wr_idx`=k and `rtc_wr_data` equal to the written byte. The RAM byte at 0x1FF7 is not disturbed.
- R8: While `pfail`=1, `pfail_n` is 0, and no read drives the bus, no write reaches RAM and no strobe is raised, for every enable combination.
- R9: Whenever `bus_drive` is 0, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for control registers |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| sel_n | input | 1 | Active-low chip enable |
| sel | input | 1 | Active-high chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| pfail | input | 1 | Power-fail indication, 1 blocks all access |
| rdata | output | 8 | Registered read data, 0 when not driven |
| bus_drive | output | 1 | Data bus driven (1) or high impedance (0) |
| pfail_n | output | 1 | Active-low power-fail output |
| rtc_rd_idx | output | 3 | Clock register index for reads |
| rtc_rdata | input | 8 | Clock register read data |
| rtc_wr_stb | output | 1 | One-cycle clock register write strobe |
| rtc_wr_idx | output | 3 | Clock register index for the strobe |
| rtc_wr_data | output | 8 | Clock register write data |

## Verification
The bench probes the border between the array and the clock window at 0x1FF7 and 0x1FF8. A decoder that is off by one there would corrupt the top RAM byte or miss the control register. It writes with each enable inactive in turn, and while power-fail is raised. An override placed on the wrong enable would let a stray write land in RAM, which the read-back after the stimulus exposes. Writes with output enable low check that output enable does not gate writes. Reads with output enable high check that the bus stays released. The bench also checks that the strobe lasts a single cycle and carries the right index, so a strobe that stuck or was decoded from the wrong address bits would show.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_HIZ   = 2'd3
  } acc_mode_t;

  // Mode decode: power fail dominates, then the enables, then we_n, then oe_n.
  function automatic acc_mode_t decode_mode(input logic pf, input logic en_n,
                                            input logic en, input logic rd_n,
                                            input logic wr_n);
    if (pf || en_n || !en) return ACC_IDLE;
    if (!wr_n)             return ACC_WRITE;
    if (!rd_n)             return ACC_READ;
    return ACC_HIZ;
  endfunction
endpackage

// File: rtl/bwr_decode.sv
module bwr_decode #(
  parameter int ADDR_W = 13,
  parameter int WIN_W  = 3
) (
  input  logic              pfail,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output bwr_pkg::acc_mode_t mode,
  output logic              in_window
);
  localparam int TAG_W = ADDR_W - WIN_W;

  function automatic logic window_hit(input logic [ADDR_W-1:0] a);
    return &a[ADDR_W-1:WIN_W];
  endfunction

  logic [TAG_W-1:0] tag_unused;
  assign tag_unused = addr[ADDR_W-1:WIN_W];

  assign mode      = bwr_pkg::decode_mode(pfail, sel_n, sel, oe_n, we_n);
  assign in_window = window_hit(addr);
endmodule

// File: rtl/bwr_ram.sv
module bwr_ram #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/bwr_rtc_port.sv
module bwr_rtc_port #(
  parameter int WIN_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [WIN_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              stb,
  output logic [WIN_W-1:0]  stb_idx,
  output logic [DATA_W-1:0] stb_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb      <= 1'b0;
      stb_idx  <= '0;
      stb_data <= '0;
    end else begin
      stb <= wr_req;
      if (wr_req) begin
        stb_idx  <= idx;
        stb_data <= wdata;
      end
    end
  end
endmodule

// File: rtl/bytewide_rtc_ram.sv
module bytewide_rtc_ram #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int WIN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              pfail,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_drive,
  output logic              pfail_n,
  output logic [WIN_W-1:0]  rtc_rd_idx,
  input  logic [DATA_W-1:0] rtc_rdata,
  output logic              rtc_wr_stb,
  output logic [WIN_W-1:0]  rtc_wr_idx,
  output logic [DATA_W-1:0] rtc_wr_data
);
  import bwr_pkg::*;

  acc_mode_t         mode;
  logic              in_window;
  logic              ram_wr;
  logic              rtc_wr;
  logic              rd_req;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] rtc_q;
  logic              rd_q;
  logic              from_rtc_q;

  bwr_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_decode (
    .pfail(pfail), .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .mode(mode), .in_window(in_window)
  );

  // Named access events
  assign ram_wr = (mode == ACC_WRITE) && !in_window;
  assign rtc_wr = (mode == ACC_WRITE) && in_window;
  assign rd_req = (mode == ACC_READ);

  bwr_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .wr_en(ram_wr), .addr(addr), .wdata(wdata), .q(ram_q)
  );

  bwr_rtc_port #(.WIN_W(WIN_W), .DATA_W(DATA_W)) u_rtc (
    .clk(clk), .rst_n(rst_n), .wr_req(rtc_wr), .idx(addr[WIN_W-1:0]),
    .wdata(wdata), .stb(rtc_wr_stb), .stb_idx(rtc_wr_idx), .stb_data(rtc_wr_data)
  );

  assign rtc_rd_idx = addr[WIN_W-1:0];
  assign pfail_n    = !pfail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q       <= 1'b0;
      from_rtc_q <= 1'b0;
      rtc_q      <= '0;
    end else begin
      rd_q       <= rd_req;
      from_rtc_q <= in_window;
      rtc_q      <= rtc_rdata;
    end
  end

  assign bus_drive = rd_q;
  assign rdata     = !rd_q ? '0 : (from_rtc_q ? rtc_q : ram_q);

  // Assertions
  a_r3_desel_release: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || !sel) |=> !bus_drive && !rtc_wr_stb);
  a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && sel && !oe_n && we_n && !pfail) |=> bus_drive);
  a_r4_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !bus_drive);
  a_r5_oe_high_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && we_n) |=> !bus_drive);
  a_r7_strobe_from_window: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_wr_stb |-> $past(&addr[ADDR_W-1:WIN_W]) && $past(!we_n));
  a_r8_pfail_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pfail |=> !bus_drive && !rtc_wr_stb);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_drive |-> rdata == '0);
endmodule

// File: tb/bytewide_rtc_ram_bench.sv
module bytewide_rtc_ram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [12:0] addr;
  logic [7:0]  wdata;
  logic        sel_n, sel, oe_n, we_n, pfail;
  logic [7:0]  rdata;
  logic        bus_drive, pfail_n;
  logic [2:0]  rtc_rd_idx;
  logic [7:0]  rtc_rdata;
  logic        rtc_wr_stb;
  logic [2:0]  rtc_wr_idx;
  logic [7:0]  rtc_wr_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  // Clock bank stand-in: a fixed pattern per index
  function automatic logic [7:0] rtc_val(input logic [2:0] k);
    return 8'h40 + 8'(k) * 8'd9;
  endfunction
  assign rtc_rdata = rtc_val(rtc_rd_idx);

  bytewide_rtc_ram u_bytewide_rtc_ram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .sel_n(sel_n),
    .sel(sel), .oe_n(oe_n), .we_n(we_n), .pfail(pfail), .rdata(rdata),
    .bus_drive(bus_drive), .pfail_n(pfail_n), .rtc_rd_idx(rtc_rd_idx),
    .rtc_rdata(rtc_rdata), .rtc_wr_stb(rtc_wr_stb), .rtc_wr_idx(rtc_wr_idx),
    .rtc_wr_data(rtc_wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sel_n = 1'b1; sel = 1'b0; oe_n = 1'b1; we_n = 1'b1; pfail = 1'b0;
  endtask

  // One access cycle driven at negedge; outputs checked at the next negedge
  task automatic cycle(input logic [12:0] a, input logic [7:0] d, input logic en_n,
                       input logic en, input logic o_n, input logic w_n, input logic pf);
    addr = a; wdata = d; sel_n = en_n; sel = en; oe_n = o_n; we_n = w_n; pfail = pf;
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic o_n);
    cycle(a, d, 1'b0, 1'b1, o_n, 1'b0, 1'b0);
  endtask

  task automatic rd_check(input string req, input logic [12:0] a, input logic [7:0] exp);
    cycle(a, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    check(req, {31'd0, bus_drive}, 32'd1);
    check(req, {24'd0, rdata}, {24'd0, exp});
  endtask

  task automatic t_reset();
    idle(); addr = '0; wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 drive", {31'd0, bus_drive}, 0);
    check("R1 rdata", {24'd0, rdata}, 0);
    check("R1 stb", {31'd0, rtc_wr_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after", {31'd0, bus_drive}, 0);
  endtask

  task automatic t_ram_rw();
    wr(13'h0000, 8'hA5, 1'b1);
    wr(13'h1FF7, 8'h3C, 1'b1);
    wr(13'h0123, 8'h77, 1'b1);
    rd_check("R2 low end", 13'h0000, 8'hA5);
    rd_check("R2 top ram", 13'h1FF7, 8'h3C);
    rd_check("R2 mid", 13'h0123, 8'h77);
  endtask

  task automatic t_deselect();
    cycle(13'h0123, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 no stb", {31'd0, rtc_wr_stb}, 0);
    cycle(13'h0123, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cycle(13'h1FF9, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3 no stb2", {31'd0, rtc_wr_stb}, 0);
    cycle(13'h0123, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R3 read no drive", {31'd0, bus_drive}, 0);
    check("R9 zero", {24'd0, rdata}, 0);
    rd_check("R3 ram kept", 13'h0123, 8'h77);
  endtask

  task automatic t_write_oe_low();
    wr(13'h0456, 8'hC3, 1'b0);
    check("R4 no drive", {31'd0, bus_drive}, 0);
    rd_check("R4 oe low write", 13'h0456, 8'hC3);
  endtask

  task automatic t_oe_high();
    cycle(13'h0456, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R5 hiz", {31'd0, bus_drive}, 0);
    check("R9 zero hiz", {24'd0, rdata}, 0);
  endtask

  task automatic t_rtc_read();
    for (int k = 0; k < 8; k++) begin
      addr = 13'h1FF8 + 13'(k); sel_n = 1'b0; sel = 1'b1; oe_n = 1'b0; we_n = 1'b1;
      #1;
      check("R6 idx", {29'd0, rtc_rd_idx}, k);
      @(negedge clk);
      idle();
      check("R6 drive", {31'd0, bus_drive}, 1);
      check("R6 data", {24'd0, rdata}, {24'd0, rtc_val(3'(k))});
    end
  endtask

  task automatic t_rtc_write();
    wr(13'h1FFB, 8'h59, 1'b1);
    check("R7 stb", {31'd0, rtc_wr_stb}, 1);
    check("R7 idx", {29'd0, rtc_wr_idx}, 3);
    check("R7 data", {24'd0, rtc_wr_data}, 32'h59);
    @(negedge clk);
    check("R7 one cycle", {31'd0, rtc_wr_stb}, 0);
    wr(13'h1FF8, 8'h80, 1'b1);
    check("R7 ctrl idx", {29'd0, rtc_wr_idx}, 0);
    wr(13'h1FFF, 8'h99, 1'b1);
    check("R7 year idx", {29'd0, rtc_wr_idx}, 7);
    rd_check("R7 border kept", 13'h1FF7, 8'h3C);
  endtask

  task automatic t_pfail();
    pfail = 1'b1; #1;
    check("R8 pfail_n", {31'd0, pfail_n}, 0);
    cycle(13'h0123, 8'hEE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    cycle(13'h1FFA, 8'hEE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R8 no stb", {31'd0, rtc_wr_stb}, 0);
    cycle(13'h0123, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R8 no drive", {31'd0, bus_drive}, 0);
    check("R9 pf zero", {24'd0, rdata}, 0);
    #1;
    check("R8 released", {31'd0, pfail_n}, 1);
    rd_check("R8 ram kept", 13'h0123, 8'h77);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ram_rw();
    t_deselect();
    t_write_oe_low();
    t_oe_high();
    t_rtc_read();
    t_rtc_write();
    t_pfail();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule